// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is a one-shot alarm that counts whole seconds down to zero. Software writes a 32-bit number of seconds into a load register; that write also copies the number into a current-value register, which software may read back at any time. Once the counter is enabled, each pulse on the one-second tick input lowers the current value by one. On the tick that brings the value to zero, a pending flag is latched.

The pending flag is combined with two independent enables. With the interrupt enable set, it raises the interrupt output. With the wakeup bit of the configuration register set, it raises the wakeup output. Software acknowledges the alarm by writing 1 to the pending bit. A second alarm's register set is present only so that software can disable it and clear it. Its enable and interrupt-enable bits read back, and its pending bit always reads zero.

To reprogram the alarm, software disables it, clears the pending flag, writes zero to the load register, then writes the new count and enables the counter again.

Top module: `cd_alarm_top`

## Requirements
- R1: After reset every register reads zero and both the interrupt and wakeup outputs are low.
- R2: A write to the load register (byte offset 0x20) stores the value there and copies it into the current-value register (offset 0x24), and both read back the written value.
- R3: The current value drops by exactly one on each tick while bit 0 of the enable register (0x28) is 1. It does not change when there is no tick or when that bit is 0.
- R4: The tick that brings the current value from 1 to 0 sets the pending flag, which reads as bit 0 of the status register (0x30) from the next cycle onward.
- R5: A current value of zero never wraps on a tick and never sets the pending flag, so loading zero cannot raise an alarm.
- R6: Writing 1 to bit 0 of the status register clears the pending flag. Writing 0 to that bit leaves the flag unchanged.
- R7: When a clear and a setting tick arrive in the same cycle, the pending flag ends up set.
- R8: The interrupt output is high exactly when the pending flag is set and bit 0 of the interrupt-enable register (0x2c) is 1.
- R9: The wakeup output is high exactly when the pending flag is set and bit 0 of the wakeup configuration register (0x50) is 1.
- R10: A load write in the same cycle as a tick takes priority. The current value becomes the written value, and that tick neither decrements it nor sets the pending flag.
- R11: For the second alarm, bit 0 of its enable register (0x44) and of its interrupt-enable register (0x48) read back as written. Its status register (0x4c) always reads zero, including after a write of 1.
- R12: The full 32-bit range counts: a load of 0xFFFFFFFF followed by one enabled tick reads 0xFFFFFFFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse once per second |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Byte offset of the register being written |
| wrData | input | DATA_W | Write data |
| rdAddr | input | ADDR_W | Byte offset of the register being read |
| rdData | output | DATA_W | Read data, combinational from rdAddr |
| irqOut | output | 1 | Alarm interrupt |
| wakeOut | output | 1 | Alarm wakeup request |

## Verification
A counter that skips a decrement or takes an extra one shows up at the current-value register in the cycle after the tick responsible. Its effect on the alarm itself only appears later, as an interrupt that comes early or late by whole seconds. A pending flag that is wrongly set or cleared appears on the status read and on both gated outputs in the next cycle. Of all the errors, a lost priority between clear and set or between load and tick would go unseen by ordinary use. For that reason the bench drives those collisions into the same cycle and reads the result back at once.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

  // Byte offsets that software decodes; kept fixed.
  localparam logic [7:0] OFF_LOAD  = 8'h20;
  localparam logic [7:0] OFF_CUR   = 8'h24;
  localparam logic [7:0] OFF_EN    = 8'h28;
  localparam logic [7:0] OFF_IE    = 8'h2C;
  localparam logic [7:0] OFF_STA   = 8'h30;
  localparam logic [7:0] OFF_EN2   = 8'h44;
  localparam logic [7:0] OFF_IE2   = 8'h48;
  localparam logic [7:0] OFF_STA2  = 8'h4C;
  localparam logic [7:0] OFF_WAKE  = 8'h50;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadWr;
    logic clrPend;
    logic countGo;
  } strobe_t;

endpackage

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] loadVal,
  input  logic [DATA_W-1:0] curVal,
  input  logic              pendFlag,
  output strobe_t           strobes,
  output logic              enBit,
  output logic              ieBit,
  output logic              wakeBit,
  output logic [DATA_W-1:0] rdData
);

  localparam int PAD_W = DATA_W - 1;

  logic en2Bit;
  logic ie2Bit;

  function automatic logic hitWr(input logic [7:0] off);
    return wrEn && (wrAddr == ADDR_W'(off));
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit   <= 1'b0;
      ieBit   <= 1'b0;
      wakeBit <= 1'b0;
      en2Bit  <= 1'b0;
      ie2Bit  <= 1'b0;
    end else begin
      if (hitWr(OFF_EN))   enBit   <= wrData[0];
      if (hitWr(OFF_IE))   ieBit   <= wrData[0];
      if (hitWr(OFF_WAKE)) wakeBit <= wrData[0];
      if (hitWr(OFF_EN2))  en2Bit  <= wrData[0];
      if (hitWr(OFF_IE2))  ie2Bit  <= wrData[0];
    end
  end

  always_comb begin
    strobes.loadWr  = hitWr(OFF_LOAD);
    strobes.clrPend = hitWr(OFF_STA) && wrData[0];
    strobes.countGo = secTick && enBit;
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(OFF_LOAD))      rdData = loadVal;
    else if (rdAddr == ADDR_W'(OFF_CUR))  rdData = curVal;
    else if (rdAddr == ADDR_W'(OFF_EN))   rdData = {{PAD_W{1'b0}}, enBit};
    else if (rdAddr == ADDR_W'(OFF_IE))   rdData = {{PAD_W{1'b0}}, ieBit};
    else if (rdAddr == ADDR_W'(OFF_STA))  rdData = {{PAD_W{1'b0}}, pendFlag};
    else if (rdAddr == ADDR_W'(OFF_WAKE)) rdData = {{PAD_W{1'b0}}, wakeBit};
    else if (rdAddr == ADDR_W'(OFF_EN2))  rdData = {{PAD_W{1'b0}}, en2Bit};
    else if (rdAddr == ADDR_W'(OFF_IE2))  rdData = {{PAD_W{1'b0}}, ie2Bit};
  end

endmodule

// File: rtl/alarm_dp.sv
module alarm_dp
  import alarm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] curVal,
  output logic             pendFlag
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic notZero;
  logic setEv;

  assign notZero = |curVal;
  assign setEv   = strobes.countGo && !strobes.loadWr && (curVal == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadVal <= '0;
      curVal  <= '0;
    end else if (strobes.loadWr) begin
      loadVal <= wrData;
      curVal  <= wrData;
    end else if (strobes.countGo && notZero) begin
      curVal  <= curVal - ONE;
    end
  end

  // Set outranks clear.
  always_ff @(posedge clk) begin
    if (!rstN) pendFlag <= 1'b0;
    else       pendFlag <= setEv || (pendFlag && !strobes.clrPend);
  end

endmodule

// File: rtl/cd_alarm_top.sv
module cd_alarm_top
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              wakeOut
);

  strobe_t           strobes;
  logic              enBit;
  logic              ieBit;
  logic              wakeBit;
  logic              pendFlag;
  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] curVal;

  alarm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .loadVal(loadVal), .curVal(curVal), .pendFlag(pendFlag),
    .strobes(strobes), .enBit(enBit), .ieBit(ieBit),
    .wakeBit(wakeBit), .rdData(rdData)
  );

  alarm_dp #(.CNT_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .loadVal(loadVal), .curVal(curVal), .pendFlag(pendFlag)
  );

  assign irqOut  = pendFlag && ieBit;
  assign wakeOut = pendFlag && wakeBit;

endmodule

// File: rtl/cd_alarm_chk.sv
module cd_alarm_chk
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              secTick,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              irqOut,
  input logic              wakeOut,
  input logic              pend,
  input logic              enOn,
  input logic [DATA_W-1:0] cur
);

  logic loadW;
  logic clrW;
  assign loadW = wrEn && (wrAddr == ADDR_W'(OFF_LOAD));
  assign clrW  = wrEn && (wrAddr == ADDR_W'(OFF_STA)) && wrData[0];

  p_dec_r3: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && enOn && !loadW && cur != '0) |=> (cur == $past(cur) - 1'b1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!secTick && !loadW) |=> $stable(cur));

  p_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && enOn && !loadW && cur == DATA_W'(1)) |=> pend);

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!loadW && cur == '0) |=> (cur == '0));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clrW && cur == '0) |=> !pend);

  p_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pend && !clrW) |=> pend);

  p_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> pend);

  p_wake_r9: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> pend);

  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (loadW && !pend) |=> !pend);

endmodule

bind cd_alarm_top cd_alarm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn),
  .wrAddr(wrAddr), .wrData(wrData), .irqOut(irqOut), .wakeOut(wakeOut),
  .pend(pendFlag), .enOn(enBit), .cur(curVal)
);

// File: tb/sim_cd_alarm_top.sv
`timescale 1ns/1ps
module sim_cd_alarm_top;
  import alarm_pkg::*;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int K_RD = 0, K_IRQ = 1, K_WAKE = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              secTick = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic              irqOut;
  logic              wakeOut;

  always #4 clk = ~clk;

  cd_alarm_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .irqOut(irqOut), .wakeOut(wakeOut)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  sampleEv;
  int    nRun = 0;
  int    nFail = 0;
  bit    finished = 0;

  // Monitor: pops expected items and compares against ports.
  initial begin
    forever begin
      @(sampleEv);
      #1;
      begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          K_IRQ:   act = {31'b0, irqOut};
          K_WAKE:  act = {31'b0, wakeOut};
          default: act = rdData;
        endcase
        nRun++;
        if (act !== it.exp) begin
          nFail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input int kind, input logic [7:0] a,
                             input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    rdAddr = ADDR_W'(a);
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> sampleEv;
    #2;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = ADDR_W'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic wrTick(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = ADDR_W'(a); wrData = d; secTick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; secTick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expect_item(K_RD, OFF_LOAD, 0, "R1 load");
    expect_item(K_RD, OFF_CUR, 0, "R1 cur");
    expect_item(K_RD, OFF_STA, 0, "R1 sta");
    expect_item(K_IRQ, 0, 0, "R1 irq");
    expect_item(K_WAKE, 0, 0, "R1 wake");
    // R2 load copies
    wr(OFF_LOAD, 5);
    expect_item(K_RD, OFF_LOAD, 5, "R2 load");
    expect_item(K_RD, OFF_CUR, 5, "R2 cur");
    // R3 disabled: no count
    tick();
    expect_item(K_RD, OFF_CUR, 5, "R3 disabled");
    wr(OFF_EN, 1);
    expect_item(K_RD, OFF_EN, 1, "R3 en readback");
    tick();
    expect_item(K_RD, OFF_CUR, 4, "R3 dec");
    tick(); tick(); tick();
    expect_item(K_RD, OFF_CUR, 1, "R3 dec3");
    expect_item(K_RD, OFF_STA, 0, "R4 not yet");
    wr(OFF_IE, 1);
    tick();
    expect_item(K_RD, OFF_CUR, 0, "R4 cur zero");
    expect_item(K_RD, OFF_STA, 1, "R4 pending");
    expect_item(K_IRQ, 0, 1, "R8 irq on");
    expect_item(K_WAKE, 0, 0, "R9 wake off");
    tick();
    expect_item(K_RD, OFF_CUR, 0, "R5 no wrap");
    wr(OFF_IE, 0);
    expect_item(K_IRQ, 0, 0, "R8 irq masked");
    wr(OFF_IE, 1);
    wr(OFF_WAKE, 1);
    expect_item(K_WAKE, 0, 1, "R9 wake on");
    wr(OFF_STA, 0);
    expect_item(K_RD, OFF_STA, 1, "R6 write0 ignored");
    wr(OFF_STA, 1);
    expect_item(K_RD, OFF_STA, 0, "R6 cleared");
    expect_item(K_IRQ, 0, 0, "R8 irq after clear");
    expect_item(K_WAKE, 0, 0, "R9 wake after clear");
    // R5 loading zero never alarms
    wr(OFF_LOAD, 0);
    tick(); tick();
    expect_item(K_RD, OFF_STA, 0, "R5 zero load");
    // R7 set and clear together
    wr(OFF_LOAD, 1);
    wrTick(OFF_STA, 1);
    expect_item(K_RD, OFF_STA, 1, "R7 set wins");
    expect_item(K_RD, OFF_CUR, 0, "R7 cur");
    wr(OFF_STA, 1);
    expect_item(K_RD, OFF_STA, 0, "R6 clear again");
    // R10 load beats tick
    wr(OFF_LOAD, 1);
    wrTick(OFF_LOAD, 3);
    expect_item(K_RD, OFF_CUR, 3, "R10 load wins");
    expect_item(K_RD, OFF_STA, 0, "R10 no pending");
    // R12 full range
    wr(OFF_LOAD, 32'hFFFF_FFFF);
    tick();
    expect_item(K_RD, OFF_CUR, 32'hFFFF_FFFE, "R12 full range");
    // R3 disable stops
    wr(OFF_EN, 0);
    tick();
    expect_item(K_RD, OFF_CUR, 32'hFFFF_FFFE, "R3 stopped");
    // R11 second alarm regs
    wr(OFF_EN2, 1);
    wr(OFF_IE2, 1);
    expect_item(K_RD, OFF_EN2, 1, "R11 en2");
    expect_item(K_RD, OFF_IE2, 1, "R11 ie2");
    wr(OFF_STA2, 1);
    expect_item(K_RD, OFF_STA2, 0, "R11 sta2");
    wr(OFF_EN2, 0);
    expect_item(K_RD, OFF_EN2, 0, "R11 en2 off");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule